// File: doc/BRIEF.md
# DSP Subsystem Power-Up Sequencer

This block is a hardware state machine that takes an embedded DSP core from full reset to a running state without software stepping through each control bit. A single start pulse captures the boot address and launches a fixed sequence. The sequence releases the subsystem resets and loads the boot vector. It turns on the crystal-reference clock and then the block head switch, and waits for the head switch acknowledge. It then lifts the supply and memory clamps in a fixed order and powers the memory banks one at a time. Last, it brings the core out of reset while holding it stopped, enables its clock and lets it run.

Every wait is measured in milliseconds derived from a tick counter whose period in clock cycles is a parameter, so the same design serves silicon time scales and short simulations. When the sequence completes, the block reports either that the core is running, after a handover indication, or that the start timed out. It reports separately when the head switch acknowledge never arrived. The block stays in either final state until reset. A start request seen at any time other than idle has no effect.

Top module: `dsp_pwrup_seq`

## Requirements
- R1: A start pulse in idle releases the subsystem resets (ss_rst_rel_o high) on the next clock edge. One edge later evb_o equals boot_addr_i[ADDR_W-1:4], the boot address shifted right by four, as sampled with the start pulse.
- R2: The reference clock enable rises one cycle after the boot vector is loaded. The head switch enable rises one cycle after that, never before the reference clock.
- R3: After the head switch is enabled, the acknowledge input is sampled once every CLK_PER_MS cycles. The first sample that sees it high advances the sequence, so the LDO bypass rises k*CLK_PER_MS+1 cycles after hs_en_o, where k is the number of that sample.
- R4: If the acknowledge is low at all ACK_TRIES samples, the sequence still advances after the last sample and hs_warn_o goes high. hs_warn_o stays low when the acknowledge is seen.
- R5: One cycle apart each, in this order: the LDO bypass turns on, the memory clamp (mem_clamp_o) is released, and peripheral sleep with L2 standby (mem_sleep_o) is released.
- R6: Memory banks are switched on singly, highest index first. The top bank turns on one cycle after the sleep release, and each lower bank turns on BANK_SETTLE_MS milliseconds after the one above.
- R7: BANK_SETTLE_MS milliseconds after bank 0 turns on, the word-line clamp is released. The I/O clamp is released one cycle later.
- R8: One cycle apart each, in this order: the core reset is released while the core is held stopped, debug retention is set, the core clock is enabled, and the stop is removed.
- R9: A handover indication in any cycle of the wait window that starts one cycle after the stop is removed sets running_o on the next edge. This includes the last cycle of the window, where the handover wins over the timeout.
- R10: Without a handover, start_timeout_o rises HANDOVER_MS*CLK_PER_MS+1 cycles after the stop is removed, and running_o stays low.
- R11: busy_o is high from the reset release until the running or timeout state is reached. A start pulse during the sequence or after it ends changes neither the boot vector nor the timing of any step.
- R12: Under reset, all enables and flags are low, evb_o is zero, all banks are off, and every clamp, the sleep control, the core reset and the core stop are asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start request pulse |
| boot_addr_i | input | ADDR_W | Core boot address |
| hs_ack_i | input | 1 | Head switch reset acknowledge |
| handover_i | input | 1 | Core handover indication |
| busy_o | output | 1 | Sequence in progress |
| running_o | output | 1 | Core is running |
| start_timeout_o | output | 1 | No handover inside the window |
| hs_warn_o | output | 1 | Head switch acknowledge never seen |
| ss_rst_rel_o | output | 1 | Subsystem resets released |
| evb_o | output | ADDR_W-4 | Boot vector (address shifted right by four) |
| xo_clk_en_o | output | 1 | Crystal-reference clock enable |
| hs_en_o | output | 1 | Head switch enable |
| ldo_bypass_o | output | 1 | LDO bypass mode |
| mem_clamp_o | output | 1 | Compiler memory clamp (1 = clamped) |
| mem_sleep_o | output | 1 | Peripheral sleep and L2 standby (1 = asserted) |
| bank_en_o | output | NUM_BANKS | Memory bank power switch enables |
| wl_clamp_o | output | 1 | Word-line clamp (1 = clamped) |
| io_clamp_o | output | 1 | I/O clamp (1 = clamped) |
| core_rst_o | output | 1 | Core reset (1 = held in reset) |
| dbg_retain_o | output | 1 | Debug state retention configured |
| core_clk_en_o | output | 1 | Core clock enable |
| core_halt_o | output | 1 | Core held stopped (1 = stopped) |

## Verification
The acknowledge latency is tried at zero, at exactly the last poll, one cycle past the last poll and never. These cases separate an acknowledge taken at a tick from a miss, and a timely acknowledge from a warned timeout. The handover is tried one cycle into the window, in its final cycle and not at all. These cases separate running from timeout and show which one wins when both fall due together. A start pulse injected during the bank phase and after completion shows that requests outside idle are dropped. Random latencies and boot addresses then run against exact cycle distances computed from the parameters for every step of the order.

// File: rtl/dsp_pwrup_pkg.sv
package dsp_pwrup_pkg;

  // Ordinal order is the power-up order; output decode relies on it.
  typedef enum logic [4:0] {
    ST_IDLE     = 5'd0,
    ST_RST      = 5'd1,
    ST_EVB      = 5'd2,
    ST_XO       = 5'd3,
    ST_HS_ON    = 5'd4,
    ST_HS_WAIT  = 5'd5,
    ST_LDO      = 5'd6,
    ST_MCLAMP   = 5'd7,
    ST_SLEEP    = 5'd8,
    ST_BANK     = 5'd9,
    ST_WL       = 5'd10,
    ST_IO       = 5'd11,
    ST_CORE_REL = 5'd12,
    ST_DBG      = 5'd13,
    ST_CLK      = 5'd14,
    ST_GO       = 5'd15,
    ST_HWAIT    = 5'd16,
    ST_RUN      = 5'd17,
    ST_FAIL     = 5'd18
  } dpu_state_e;

endpackage

// File: rtl/dsp_pwrup_timer.sv
module dsp_pwrup_timer #(
  parameter int CLK_PER_MS = 100000,
  parameter int MS_W       = 13
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            restart_i,
  output logic            tick_o,
  output logic [MS_W-1:0] ms_cnt_o
);

  localparam int CYC_W = (CLK_PER_MS > 1) ? $clog2(CLK_PER_MS) : 1;

  logic [CYC_W-1:0] cyc_q, cyc_d;
  logic [MS_W-1:0]  ms_q, ms_d;

  assign tick_o   = (cyc_q == CYC_W'(CLK_PER_MS - 1));
  assign ms_cnt_o = ms_q;

  always_comb begin
    cyc_d = cyc_q;
    ms_d  = ms_q;
    if (restart_i) begin
      cyc_d = '0;
      ms_d  = '0;
    end else if (tick_o) begin
      cyc_d = '0;
      if (ms_q != '1) ms_d = ms_q + 1'b1;
    end else begin
      cyc_d = cyc_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc_q <= '0;
      ms_q  <= '0;
    end else begin
      cyc_q <= cyc_d;
      ms_q  <= ms_d;
    end
  end

  AST_CYC_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_q <= CYC_W'(CLK_PER_MS - 1)); // R3

endmodule

// File: rtl/dsp_pwrup_decode.sv
module dsp_pwrup_decode
  import dsp_pwrup_pkg::*;
#(
  parameter int NUM_BANKS = 20,
  parameter int IDX_W     = 5
) (
  input  dpu_state_e           state_i,
  input  logic [IDX_W-1:0]     bank_idx_i,
  output logic                 busy_o,
  output logic                 running_o,
  output logic                 timeout_o,
  output logic                 ss_rel_o,
  output logic                 xo_en_o,
  output logic                 hs_en_o,
  output logic                 ldo_byp_o,
  output logic                 mem_clamp_o,
  output logic                 mem_sleep_o,
  output logic [NUM_BANKS-1:0] bank_en_o,
  output logic                 wl_clamp_o,
  output logic                 io_clamp_o,
  output logic                 core_rst_o,
  output logic                 dbg_ret_o,
  output logic                 core_clk_o,
  output logic                 core_halt_o
);

  // Each control changes once, when its step is entered, and keeps that
  // level in every later state, so it decodes as a compare on the ordinal.
  assign busy_o      = (state_i != ST_IDLE) && (state_i != ST_RUN) && (state_i != ST_FAIL);
  assign running_o   = (state_i == ST_RUN);
  assign timeout_o   = (state_i == ST_FAIL);
  assign ss_rel_o    = (state_i >= ST_RST);
  assign xo_en_o     = (state_i >= ST_XO);
  assign hs_en_o     = (state_i >= ST_HS_ON);
  assign ldo_byp_o   = (state_i >= ST_LDO);
  assign mem_clamp_o = (state_i <  ST_MCLAMP);
  assign mem_sleep_o = (state_i <  ST_SLEEP);
  assign wl_clamp_o  = (state_i <  ST_WL);
  assign io_clamp_o  = (state_i <  ST_IO);
  assign core_rst_o  = (state_i <  ST_CORE_REL);
  assign dbg_ret_o   = (state_i >= ST_DBG);
  assign core_clk_o  = (state_i >= ST_CLK);
  assign core_halt_o = (state_i <  ST_GO);

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    assign bank_en_o[b] = (state_i > ST_BANK) ||
                          ((state_i == ST_BANK) && (IDX_W'(b) >= bank_idx_i));
  end

endmodule

// File: rtl/dsp_pwrup_seq.sv
module dsp_pwrup_seq
  import dsp_pwrup_pkg::*;
#(
  parameter int CLK_PER_MS     = 100000,
  parameter int NUM_BANKS      = 20,
  parameter int ACK_TRIES      = 10,
  parameter int BANK_SETTLE_MS = 10,
  parameter int HANDOVER_MS    = 5000,
  parameter int ADDR_W         = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start_i,
  input  logic [ADDR_W-1:0]    boot_addr_i,
  input  logic                 hs_ack_i,
  input  logic                 handover_i,
  output logic                 busy_o,
  output logic                 running_o,
  output logic                 start_timeout_o,
  output logic                 hs_warn_o,
  output logic                 ss_rst_rel_o,
  output logic [ADDR_W-5:0]    evb_o,
  output logic                 xo_clk_en_o,
  output logic                 hs_en_o,
  output logic                 ldo_bypass_o,
  output logic                 mem_clamp_o,
  output logic                 mem_sleep_o,
  output logic [NUM_BANKS-1:0] bank_en_o,
  output logic                 wl_clamp_o,
  output logic                 io_clamp_o,
  output logic                 core_rst_o,
  output logic                 dbg_retain_o,
  output logic                 core_clk_en_o,
  output logic                 core_halt_o
);

  localparam int EVB_W  = ADDR_W - 4;
  localparam int IDX_W  = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;
  localparam int MAX_A  = (ACK_TRIES > BANK_SETTLE_MS) ? ACK_TRIES : BANK_SETTLE_MS;
  localparam int MS_MAX = (MAX_A > HANDOVER_MS) ? MAX_A : HANDOVER_MS;
  localparam int MS_W   = $clog2(MS_MAX + 1);

  dpu_state_e        state_q, state_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic [EVB_W-1:0]  addr_q, addr_d;
  logic [EVB_W-1:0]  evb_d;
  logic              warn_q, warn_d;
  logic              bank_step;
  logic              restart;
  logic              tick;
  logic [MS_W-1:0]   ms_cnt;
  logic              unused_addr_lo;

  assign unused_addr_lo = ^boot_addr_i[3:0];

  // Decoded next-cycle controls
  logic                 dec_busy, dec_run, dec_to, dec_ss, dec_xo, dec_hs, dec_ldo;
  logic                 dec_mclamp, dec_sleep, dec_wl, dec_io, dec_crst, dec_dbg;
  logic                 dec_cclk, dec_halt;
  logic [NUM_BANKS-1:0] dec_bank;

  assign restart = (state_d != state_q) || bank_step;

  dsp_pwrup_timer #(
    .CLK_PER_MS (CLK_PER_MS),
    .MS_W       (MS_W)
  ) timer_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .restart_i (restart),
    .tick_o    (tick),
    .ms_cnt_o  (ms_cnt)
  );

  // Next-state process
  always_comb begin
    state_d   = state_q;
    idx_d     = idx_q;
    addr_d    = addr_q;
    warn_d    = warn_q;
    bank_step = 1'b0;
    unique case (state_q)
      ST_IDLE: if (start_i) begin
        state_d = ST_RST;
        addr_d  = boot_addr_i[ADDR_W-1:4];
        warn_d  = 1'b0;
      end
      ST_RST:     state_d = ST_EVB;
      ST_EVB:     state_d = ST_XO;
      ST_XO:      state_d = ST_HS_ON;
      ST_HS_ON:   state_d = ST_HS_WAIT;
      ST_HS_WAIT: if (tick) begin
        if (hs_ack_i) begin
          state_d = ST_LDO;
        end else if (ms_cnt == MS_W'(ACK_TRIES - 1)) begin
          state_d = ST_LDO;
          warn_d  = 1'b1;
        end
      end
      ST_LDO:     state_d = ST_MCLAMP;
      ST_MCLAMP:  state_d = ST_SLEEP;
      ST_SLEEP: begin
        state_d = ST_BANK;
        idx_d   = IDX_W'(NUM_BANKS - 1);
      end
      ST_BANK: if (tick && (ms_cnt == MS_W'(BANK_SETTLE_MS - 1))) begin
        if (idx_q == '0) begin
          state_d = ST_WL;
        end else begin
          idx_d     = idx_q - 1'b1;
          bank_step = 1'b1;
        end
      end
      ST_WL:       state_d = ST_IO;
      ST_IO:       state_d = ST_CORE_REL;
      ST_CORE_REL: state_d = ST_DBG;
      ST_DBG:      state_d = ST_CLK;
      ST_CLK:      state_d = ST_GO;
      ST_GO:       state_d = ST_HWAIT;
      ST_HWAIT: begin
        if (handover_i) begin
          state_d = ST_RUN;
        end else if (tick && (ms_cnt == MS_W'(HANDOVER_MS - 1))) begin
          state_d = ST_FAIL;
        end
      end
      ST_RUN:  state_d = ST_RUN;
      ST_FAIL: state_d = ST_FAIL;
      default: state_d = ST_IDLE;
    endcase
  end

  assign evb_d = (state_d == ST_EVB) ? addr_q : evb_o;

  dsp_pwrup_decode #(
    .NUM_BANKS (NUM_BANKS),
    .IDX_W     (IDX_W)
  ) decode_i (
    .state_i     (state_d),
    .bank_idx_i  (idx_d),
    .busy_o      (dec_busy),
    .running_o   (dec_run),
    .timeout_o   (dec_to),
    .ss_rel_o    (dec_ss),
    .xo_en_o     (dec_xo),
    .hs_en_o     (dec_hs),
    .ldo_byp_o   (dec_ldo),
    .mem_clamp_o (dec_mclamp),
    .mem_sleep_o (dec_sleep),
    .bank_en_o   (dec_bank),
    .wl_clamp_o  (dec_wl),
    .io_clamp_o  (dec_io),
    .core_rst_o  (dec_crst),
    .dbg_ret_o   (dec_dbg),
    .core_clk_o  (dec_cclk),
    .core_halt_o (dec_halt)
  );

  // Register process: all controls leave the block from flops
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q         <= ST_IDLE;
      idx_q           <= '0;
      addr_q          <= '0;
      warn_q          <= 1'b0;
      evb_o           <= '0;
      busy_o          <= 1'b0;
      running_o       <= 1'b0;
      start_timeout_o <= 1'b0;
      ss_rst_rel_o    <= 1'b0;
      xo_clk_en_o     <= 1'b0;
      hs_en_o         <= 1'b0;
      ldo_bypass_o    <= 1'b0;
      mem_clamp_o     <= 1'b1;
      mem_sleep_o     <= 1'b1;
      bank_en_o       <= '0;
      wl_clamp_o      <= 1'b1;
      io_clamp_o      <= 1'b1;
      core_rst_o      <= 1'b1;
      dbg_retain_o    <= 1'b0;
      core_clk_en_o   <= 1'b0;
      core_halt_o     <= 1'b1;
    end else begin
      state_q         <= state_d;
      idx_q           <= idx_d;
      addr_q          <= addr_d;
      warn_q          <= warn_d;
      evb_o           <= evb_d;
      busy_o          <= dec_busy;
      running_o       <= dec_run;
      start_timeout_o <= dec_to;
      ss_rst_rel_o    <= dec_ss;
      xo_clk_en_o     <= dec_xo;
      hs_en_o         <= dec_hs;
      ldo_bypass_o    <= dec_ldo;
      mem_clamp_o     <= dec_mclamp;
      mem_sleep_o     <= dec_sleep;
      bank_en_o       <= dec_bank;
      wl_clamp_o      <= dec_wl;
      io_clamp_o      <= dec_io;
      core_rst_o      <= dec_crst;
      dbg_retain_o    <= dec_dbg;
      core_clk_en_o   <= dec_cclk;
      core_halt_o     <= dec_halt;
    end
  end

  assign hs_warn_o = warn_q;

  AST_XO_BEFORE_HS: assert property (@(posedge clk) disable iff (!rst_n)
    hs_en_o |-> xo_clk_en_o); // R2
  AST_HS_BEFORE_LDO: assert property (@(posedge clk) disable iff (!rst_n)
    ldo_bypass_o |-> hs_en_o); // R3
  AST_CLAMP_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_sleep_o |-> (!mem_clamp_o && ldo_bypass_o)); // R5
  AST_BANK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (bank_en_o != $past(bank_en_o)) |-> ($countones(bank_en_o ^ $past(bank_en_o)) == 1)); // R6
  AST_BANK_TOP_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (|bank_en_o) |-> (bank_en_o[NUM_BANKS-1] && !mem_sleep_o)); // R6
  AST_WL_BEFORE_IO: assert property (@(posedge clk) disable iff (!rst_n)
    !io_clamp_o |-> (!wl_clamp_o && (&bank_en_o))); // R7
  AST_CORE_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    !core_halt_o |-> (core_clk_en_o && dbg_retain_o && !core_rst_o && !io_clamp_o)); // R8
  AST_CLK_AFTER_REL: assert property (@(posedge clk) disable iff (!rst_n)
    core_clk_en_o |-> (!core_rst_o && core_halt_o || !core_halt_o)); // R8
  AST_END_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(running_o && start_timeout_o)); // R10
  AST_RUN_AFTER_GO: assert property (@(posedge clk) disable iff (!rst_n)
    running_o |-> !core_halt_o); // R9
  AST_BUSY_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> !(running_o || start_timeout_o)); // R11
  AST_EVB_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (xo_clk_en_o && $past(xo_clk_en_o)) |-> $stable(evb_o)); // R11

endmodule

// File: tb/dsp_pwrup_seq_tb_top.sv
module dsp_pwrup_seq_tb_top;

  localparam int CPM   = 8;
  localparam int NB    = 20;
  localparam int TRIES = 10;
  localparam int SET   = 10;
  localparam int HO    = 40;
  localparam int AW    = 32;
  localparam int NEVER = 1000000;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          start_i;
  logic [AW-1:0] boot_addr_i;
  logic          hs_ack_i;
  logic          handover_i;
  logic          busy_o, running_o, start_timeout_o, hs_warn_o, ss_rst_rel_o;
  logic [AW-5:0] evb_o;
  logic          xo_clk_en_o, hs_en_o, ldo_bypass_o, mem_clamp_o, mem_sleep_o;
  logic [NB-1:0] bank_en_o;
  logic          wl_clamp_o, io_clamp_o, core_rst_o, dbg_retain_o, core_clk_en_o, core_halt_o;

  always #5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  dsp_pwrup_seq #(
    .CLK_PER_MS     (CPM),
    .NUM_BANKS      (NB),
    .ACK_TRIES      (TRIES),
    .BANK_SETTLE_MS (SET),
    .HANDOVER_MS    (HO),
    .ADDR_W         (AW)
  ) dut_i (
    .clk (clk), .rst_n (rst_n), .start_i (start_i), .boot_addr_i (boot_addr_i),
    .hs_ack_i (hs_ack_i), .handover_i (handover_i), .busy_o (busy_o),
    .running_o (running_o), .start_timeout_o (start_timeout_o), .hs_warn_o (hs_warn_o),
    .ss_rst_rel_o (ss_rst_rel_o), .evb_o (evb_o), .xo_clk_en_o (xo_clk_en_o),
    .hs_en_o (hs_en_o), .ldo_bypass_o (ldo_bypass_o), .mem_clamp_o (mem_clamp_o),
    .mem_sleep_o (mem_sleep_o), .bank_en_o (bank_en_o), .wl_clamp_o (wl_clamp_o),
    .io_clamp_o (io_clamp_o), .core_rst_o (core_rst_o), .dbg_retain_o (dbg_retain_o),
    .core_clk_en_o (core_clk_en_o), .core_halt_o (core_halt_o)
  );

  task automatic chk_eq(input string tag, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Poll number at which the acknowledge is first seen (R3/R4)
  function automatic int exp_polls(input int lat);
    int k;
    k = (lat + CPM - 1) / CPM;
    if (k < 1) k = 1;
    if (k > TRIES) k = TRIES;
    return k;
  endfunction

  function automatic bit exp_warn(input int lat);
    return (lat > TRIES * CPM);
  endfunction

  task automatic run_one(input logic [AW-1:0] addr, input int ack_lat,
                         input int ho_dly, input bit mid_start);
    int t_start, t_rel, t_evb, t_xo, t_hs, t_ldo, t_mc, t_sl, t_wl, t_io;
    int t_cr, t_dbg, t_clk, t_go, t_run, t_to, busy_bad, mis, iter;
    int t_bank[NB];
    logic [AW-5:0] exp_evb;
    logic [AW+12:0] rest;
    exp_evb = addr[AW-1:4];

    rst_n = 1'b0; start_i = 1'b0; hs_ack_i = 1'b0; handover_i = 1'b0;
    boot_addr_i = '0;
    repeat (3) @(negedge clk);
    // R12: rest state while reset is held
    rest = {busy_o, running_o, start_timeout_o, hs_warn_o, ss_rst_rel_o, evb_o,
            xo_clk_en_o, hs_en_o, ldo_bypass_o, mem_clamp_o, mem_sleep_o,
            |bank_en_o, wl_clamp_o, io_clamp_o, core_rst_o, dbg_retain_o,
            core_clk_en_o, core_halt_o};
    chk_eq("R12 reset state", longint'(rest),
           longint'({5'b0, {(AW-4){1'b0}}, 3'b000, 2'b11, 1'b0, 3'b111, 2'b00, 1'b1}));
    rst_n = 1'b1;
    @(negedge clk);

    t_rel = -1; t_evb = -1; t_xo = -1; t_hs = -1; t_ldo = -1; t_mc = -1; t_sl = -1;
    t_wl = -1; t_io = -1; t_cr = -1; t_dbg = -1; t_clk = -1; t_go = -1;
    t_run = -1; t_to = -1; busy_bad = 0;
    foreach (t_bank[b]) t_bank[b] = -1;

    start_i = 1'b1; boot_addr_i = addr; t_start = cyc;
    iter = 0;
    while (iter < 20000 && t_run < 0 && t_to < 0) begin
      @(negedge clk);
      iter++;
      start_i = 1'b0;
      boot_addr_i = ~addr;
      if (t_rel < 0 && ss_rst_rel_o)      t_rel = cyc;
      if (t_evb < 0 && evb_o == exp_evb)   t_evb = cyc;
      if (t_xo  < 0 && xo_clk_en_o)       t_xo  = cyc;
      if (t_hs  < 0 && hs_en_o)           t_hs  = cyc;
      if (t_ldo < 0 && ldo_bypass_o)      t_ldo = cyc;
      if (t_mc  < 0 && !mem_clamp_o)      t_mc  = cyc;
      if (t_sl  < 0 && !mem_sleep_o)      t_sl  = cyc;
      for (int b = 0; b < NB; b++)
        if (t_bank[b] < 0 && bank_en_o[b]) t_bank[b] = cyc;
      if (t_wl  < 0 && !wl_clamp_o)       t_wl  = cyc;
      if (t_io  < 0 && !io_clamp_o)       t_io  = cyc;
      if (t_cr  < 0 && !core_rst_o)       t_cr  = cyc;
      if (t_dbg < 0 && dbg_retain_o)      t_dbg = cyc;
      if (t_clk < 0 && core_clk_en_o)     t_clk = cyc;
      if (t_go  < 0 && !core_halt_o)      t_go  = cyc;
      if (t_run < 0 && running_o)         t_run = cyc;
      if (t_to  < 0 && start_timeout_o)   t_to  = cyc;
      if (t_rel >= 0 && !running_o && !start_timeout_o && !busy_o) busy_bad++;
      hs_ack_i   = (t_hs >= 0) && (cyc - t_hs >= ack_lat);
      handover_i = (ho_dly >= 0) && (t_go >= 0) && (cyc - t_go >= ho_dly);
      if (mid_start && t_bank[NB-1] >= 0 && cyc == t_bank[NB-1] + 3) begin
        start_i = 1'b1;
        boot_addr_i = ~addr;
      end
    end
    if (iter >= 20000) chk_eq("watchdog run hung", iter, 0);

    chk_eq("R1 reset release", t_rel, t_start + 1);
    chk_eq("R1 boot vector", t_evb, t_rel + 1);
    chk_eq("R2 ref clock", t_xo, t_evb + 1);
    chk_eq("R2 head switch", t_hs, t_xo + 1);
    chk_eq("R3 ack poll", t_ldo, t_hs + exp_polls(ack_lat) * CPM + 1);
    chk_eq("R4 warn flag", hs_warn_o, exp_warn(ack_lat));
    chk_eq("R5 mem clamp", t_mc, t_ldo + 1);
    chk_eq("R5 sleep release", t_sl, t_mc + 1);
    chk_eq("R6 top bank", t_bank[NB-1], t_sl + 1);
    mis = 0;
    for (int b = NB - 2; b >= 0; b--)
      if (t_bank[b] != t_bank[b+1] + SET * CPM) mis++;
    chk_eq("R6 bank spacing", mis, 0);
    chk_eq("R7 word-line clamp", t_wl, t_bank[0] + SET * CPM);
    chk_eq("R7 io clamp", t_io, t_wl + 1);
    chk_eq("R8 core reset", t_cr, t_io + 1);
    chk_eq("R8 debug retain", t_dbg, t_cr + 1);
    chk_eq("R8 core clock", t_clk, t_dbg + 1);
    chk_eq("R8 run", t_go, t_clk + 1);
    if (ho_dly >= 1 && ho_dly <= HO * CPM) begin
      chk_eq("R9 running", t_run, t_go + ho_dly + 1);
      chk_eq("R9 no timeout", start_timeout_o, 0);
    end else begin
      chk_eq("R10 timeout", t_to, t_go + HO * CPM + 1);
      chk_eq("R10 not running", running_o, 0);
    end
    chk_eq("R11 busy span", busy_bad, 0);
    chk_eq("R11 vector kept", longint'(evb_o), longint'(exp_evb));

    // R11: start after completion has no effect
    start_i = 1'b1; boot_addr_i = ~addr;
    @(negedge clk);
    start_i = 1'b0;
    repeat (5) @(negedge clk);
    chk_eq("R11 late start busy", busy_o, 0);
    chk_eq("R11 late start vector", longint'(evb_o), longint'(exp_evb));
    chk_eq("R11 late start banks", longint'(bank_en_o), longint'({NB{1'b1}}));
  endtask

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; start_i = 1'b0; hs_ack_i = 1'b0; handover_i = 1'b0; boot_addr_i = '0;
    // Directed corners
    run_one(32'h8000_1230, 0, 1, 1'b0);
    run_one(32'h1234_5670, TRIES * CPM, HO * CPM, 1'b0);
    run_one(32'hCAFE_0010, TRIES * CPM + 1, -1, 1'b0);
    run_one(32'h0F0F_F0F0, NEVER, 5, 1'b1);
    // Random runs
    for (int r = 0; r < 4; r++) begin
      logic [AW-1:0] a;
      int lat, ho;
      a   = $urandom() | 32'h0000_0100;
      lat = $urandom_range(0, TRIES * CPM + 20);
      ho  = $urandom_range(1, HO * CPM + 30);
      run_one(a, lat, ho, r[0]);
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

endmodule